// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast system clock into a strobe that fires at sixteen times a serial line's bit rate. It needs no integer divider. A 24-bit phase accumulator adds a programmable increment on every system clock. Each time the sum wraps past 2^24, the block raises a one-cycle tick. The tick frequency is therefore f_clk × increment / 2^24, and the rate can be set in steps of f_clk / 2^24.

The increment is held as three byte-wide registers. A host loads them one byte at a time through a small write port and can read each byte back. A parameter sets the value loaded at reset, so the generator runs at a chosen default rate without any software setup. The increment is the upper 24 bits of round(baud × 16 × 2^32 / f_clk). For example, 38400 baud on a 28.63636 MHz clock needs 0x057E17. A serial shifter downstream counts 16 ticks per bit. Tick spacing may vary by one system clock, and the 16x oversampling absorbs this.

Top module: `baud_tick_gen`

## Requirements
- R1: During and right after a synchronous reset (`rst` high), `tick` is 0 and the increment equals the `INC_RESET` parameter. Its default is 0x057E17, so after reset the read indices return 0x17 (index 0), 0x7E (index 1) and 0x05 (index 2).
- R2: When `wr_en` is 1, each set bit of `wr_sel` loads `wr_data` into its byte: bit 0 loads bits 7:0, bit 1 loads bits 15:8 and bit 2 loads bits 23:16. Bytes whose select bit is clear keep their value.
- R3: `rd_data` combinationally returns the increment byte chosen by `rd_sel`: 0 for the low byte, 1 for the middle byte, 2 for the high byte. Index 3 reads as 0x00.
- R4: Over a window of C clocks with a constant increment N, the number of ticks equals C × N / 2^24 within ±1.
- R5: `tick` lasts exactly one clock whenever the increment is below 0x800000. With increment 0x400000, ticks come exactly every 4 clocks.
- R6: A byte write takes effect on the add at the next clock edge and does not reset the accumulator phase.
- R7: With increment 0, `tick` stays 0.
- R8: While `wr_en` is 0, the increment does not change, whatever `wr_sel` and `wr_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 3 | One bit per increment byte (bit 0 = low byte) |
| wr_data | input | 8 | Byte to write |
| rd_sel | input | 2 | Readback byte index (3 reads zero) |
| rd_data | output | 8 | Selected increment byte |
| tick | output | 1 | One-cycle strobe at 16x baud |

## Verification
The hardest case to reach from the ports is phase continuity across a rewrite. This is because the accumulator value is never visible. The bench sets an increment of 0x400000 and waits for a tick, which pins the phase to one of four known slots. Exactly two edges later it changes only the high byte to 0x80. A continuing phase gives the next tick one edge after the write lands. A phase cleared on write would delay that tick by one more edge. Rate accuracy is measured by counting ticks over fixed windows for increments ranging from zero to all ones.

// File: rtl/baud_synth_pkg.sv
package baud_synth_pkg;

    localparam int BYTE_BITS = 8;

    typedef logic [BYTE_BITS-1:0] byte_t;

    // Index width for a readback mux covering n entries (at least 1 bit).
    function automatic int idx_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/baud_inc_regs.sv
module baud_inc_regs #(
    parameter int NBYTES = 3,
    parameter int BYTE_W = 8,
    parameter logic [NBYTES*BYTE_W-1:0] RESET_VAL = '0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [NBYTES-1:0]        wr_sel,
    input  logic [BYTE_W-1:0]        wr_data,
    output logic [NBYTES*BYTE_W-1:0] inc
);
    localparam int TOT_W = NBYTES * BYTE_W;

    typedef struct packed {
        logic [NBYTES-1:0][BYTE_W-1:0] bytes;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [NBYTES-1:0][BYTE_W-1:0] byte_nxt;

    // Per-byte next value: load on a selected write, otherwise hold.
    for (genvar gi = 0; gi < NBYTES; gi++) begin : g_byte
        always_comb begin
            if (wr_en && wr_sel[gi]) begin
                byte_nxt[gi] = wr_data;
            end else begin
                byte_nxt[gi] = regs_q.bytes[gi];
            end
        end
    end

    always_comb begin
        regs_d = regs_q;
        regs_d.bytes = byte_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.bytes <= RESET_VAL;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign inc = TOT_W'(regs_q.bytes);
endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
    parameter int ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] inc,
    output logic             tick
);
    typedef struct packed {
        logic [ACC_W-1:0] phase;
        logic             tick;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [ACC_W:0] sum_w;

    always_comb begin
        acc_d       = acc_q;
        sum_w       = {1'b0, acc_q.phase} + {1'b0, inc};
        acc_d.phase = sum_w[ACC_W-1:0];
        acc_d.tick  = sum_w[ACC_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign tick = acc_q.tick;
endmodule

// File: rtl/baud_rd_mux.sv
module baud_rd_mux #(
    parameter int NBYTES = 3,
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic [NBYTES*BYTE_W-1:0] inc,
    input  logic [SEL_W-1:0]         rd_sel,
    output logic [BYTE_W-1:0]        rd_data
);
    logic [NBYTES-1:0][BYTE_W-1:0] as_bytes;

    assign as_bytes = inc;

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (int'(rd_sel) == i) begin
                rd_data = as_bytes[i];
            end
        end
    end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int INC_BYTES = 3,
    parameter int BYTE_W    = baud_synth_pkg::BYTE_BITS,
    parameter logic [INC_BYTES*BYTE_W-1:0] INC_RESET = 24'h057E17
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [INC_BYTES-1:0]   wr_sel,
    input  logic [BYTE_W-1:0]      wr_data,
    input  logic [baud_synth_pkg::idx_width(INC_BYTES+1)-1:0] rd_sel,
    output logic [BYTE_W-1:0]      rd_data,
    output logic                   tick
);
    localparam int ACC_W = INC_BYTES * BYTE_W;
    localparam int SEL_W = baud_synth_pkg::idx_width(INC_BYTES + 1);

    logic [ACC_W-1:0] inc_w;

    baud_inc_regs #(
        .NBYTES   (INC_BYTES),
        .BYTE_W   (BYTE_W),
        .RESET_VAL(INC_RESET)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .inc    (inc_w)
    );

    baud_phase_acc #(
        .ACC_W(ACC_W)
    ) u_acc (
        .clk (clk),
        .rst (rst),
        .inc (inc_w),
        .tick(tick)
    );

    baud_rd_mux #(
        .NBYTES(INC_BYTES),
        .BYTE_W(BYTE_W),
        .SEL_W (SEL_W)
    ) u_rd (
        .inc    (inc_w),
        .rd_sel (rd_sel),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/baud_tick_gen_checker.sv
module baud_tick_gen_checker #(
    parameter int NBYTES = 3,
    parameter int BYTE_W = 8,
    parameter logic [NBYTES*BYTE_W-1:0] RESET_VAL = '0
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_en,
    input logic [NBYTES-1:0]        wr_sel,
    input logic [BYTE_W-1:0]        wr_data,
    input logic [NBYTES*BYTE_W-1:0] inc,
    input logic                     tick
);
    localparam int TOT_W = NBYTES * BYTE_W;

    // R1: first cycle after reset has no tick and the default increment
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tick && inc == RESET_VAL));

    // R2: a selected byte holds the written data one edge later
    for (genvar gi = 0; gi < NBYTES; gi++) begin : g_wr
        a_r2_byte_load: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_sel[gi]) |=> inc[gi*BYTE_W +: BYTE_W] == $past(wr_data));
        a_r2_byte_keep: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !wr_sel[gi]) |=> $stable(inc[gi*BYTE_W +: BYTE_W]));
    end

    // R5: with a stable increment below half scale, a tick never repeats
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (tick && $stable(inc) && !inc[TOT_W-1]) |=> !tick);

    // R7: a zero increment never produces a tick
    a_r7_zero_silent: assert property (@(posedge clk) disable iff (rst)
        (inc == '0) |=> !tick);

    // R8: no write strobe, no change
    a_r8_no_write_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(inc));
endmodule

bind baud_tick_gen baud_tick_gen_checker #(
    .NBYTES   (INC_BYTES),
    .BYTE_W   (BYTE_W),
    .RESET_VAL(INC_RESET)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .inc    (inc_w),
    .tick   (tick)
);

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WINDOW     = 16384;   // clocks per counting window
    localparam int NVEC       = 6;

    // {increment, expected ticks = floor(inc * WINDOW / 2^24)}
    localparam logic [23:0] VEC_INC [NVEC] = '{24'h057E17, 24'h000400, 24'h800000,
                                               24'hFFFFFF, 24'h123456, 24'h000000};
    localparam int          VEC_EXP [NVEC] = '{351, 1, 8192, 16383, 1165, 0};

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [2:0] wr_sel;
    logic [7:0] wr_data;
    logic [1:0] rd_sel;
    logic [7:0] rd_data;
    logic       tick;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_tick_gen u_baud_tick_gen (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .rd_sel (rd_sel),
        .rd_data(rd_data),
        .tick   (tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic write_byte(input logic [2:0] sel, input logic [7:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = '0;
    endtask

    task automatic write_inc(input logic [23:0] v);
        write_byte(3'b001, v[7:0]);
        write_byte(3'b010, v[15:8]);
        write_byte(3'b100, v[23:16]);
        @(negedge clk);   // let the last write reach the add
    endtask

    task automatic read_byte(input logic [1:0] idx, output logic [7:0] val);
        rd_sel = idx;
        #1;
        val = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rb;
        int cnt;
        int last;
        bit dbl;
        rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
        repeat (3) @(negedge clk);
        check(tick == 1'b0, "R1 tick in reset", tick, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tick == 1'b0, "R1 tick after reset", tick, 0);

        // R1 / R3: default increment readback
        read_byte(2'd0, rb); check(rb == 8'h17, "R1 R3 low byte", rb, 8'h17);
        read_byte(2'd1, rb); check(rb == 8'h7E, "R1 R3 mid byte", rb, 8'h7E);
        read_byte(2'd2, rb); check(rb == 8'h05, "R1 R3 high byte", rb, 8'h05);
        read_byte(2'd3, rb); check(rb == 8'h00, "R3 index 3 zero", rb, 0);

        // R2: only the middle byte changes
        write_byte(3'b010, 8'hA5);
        read_byte(2'd0, rb); check(rb == 8'h17, "R2 low kept", rb, 8'h17);
        read_byte(2'd1, rb); check(rb == 8'hA5, "R2 mid loaded", rb, 8'hA5);
        read_byte(2'd2, rb); check(rb == 8'h05, "R2 high kept", rb, 8'h05);

        // R8: strobe low, selects and data active
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 3'b111; wr_data = 8'hFF;
        repeat (3) @(negedge clk);
        wr_sel = '0;
        read_byte(2'd0, rb); check(rb == 8'h17, "R8 low unchanged", rb, 8'h17);
        read_byte(2'd1, rb); check(rb == 8'hA5, "R8 mid unchanged", rb, 8'hA5);
        read_byte(2'd2, rb); check(rb == 8'h05, "R8 high unchanged", rb, 8'h05);

        // R4 / R7: rate table
        for (int v = 0; v < NVEC; v++) begin
            write_inc(VEC_INC[v]);
            cnt = 0;
            for (int c = 0; c < WINDOW; c++) begin
                @(negedge clk);
                if (tick) cnt++;
            end
            if (VEC_INC[v] == 24'h0)
                check(cnt == 0, "R7 zero increment ticks", cnt, 0);
            else
                check(cnt >= VEC_EXP[v] - 1 && cnt <= VEC_EXP[v] + 1,
                      "R4 tick count", cnt, VEC_EXP[v]);
        end

        // R5: period 4, single-cycle pulses
        write_inc(24'h400000);
        cnt = 0; last = 0; dbl = 1'b0;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            if (tick) cnt++;
            if (tick && last == 1) dbl = 1'b1;
            last = tick;
        end
        check(cnt == 4, "R5 ticks in 16 clocks", cnt, 4);
        check(dbl == 1'b0, "R5 single pulse", dbl, 0);

        // R6: phase kept across a write
        while (tick != 1'b1) @(negedge clk);   // just after edge e
        @(negedge clk);                        // after e+1
        wr_en = 1'b1; wr_sel = 3'b100; wr_data = 8'h80;
        @(negedge clk);                        // after e+2 (write landed)
        wr_en = 1'b0; wr_sel = '0;
        check(tick == 1'b0, "R6 no tick at e+2", tick, 0);
        @(negedge clk);                        // after e+3
        check(tick == 1'b1, "R6 tick at e+3 (phase kept)", tick, 1);

        // R1: reset mid-run restores the default
        rst = 1'b1;
        @(negedge clk);
        check(tick == 1'b0, "R1 tick on reset", tick, 0);
        rst = 1'b0;
        read_byte(2'd2, rb); check(rb == 8'h05, "R1 high restored", rb, 8'h05);
        read_byte(2'd1, rb); check(rb == 8'h7E, "R1 mid restored", rb, 8'h7E);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule